// File: doc/BRIEF.md
# Open-Load Fault Supervisor

This block supervises the faults of a twelve-channel constant-current LED driver. Raw comparator flags arrive for each channel's open-load detector, along with a diagnostic-enable level, the sensed level of a shared open-drain diagnostic line, thermal warning and shutdown flags, a set-resistor short flag, an undervoltage flag and a communication-error strobe. Open-load flags, the external pull-down on the diagnostic line and the set-resistor short are filtered by a small state machine each. A fault is accepted only after it has persisted for a number of millisecond ticks, and is dropped only after it has been absent for the same number of ticks.

The filtered faults feed a status byte, a per-channel fault register that clears when it is read, the active-low open-drain diagnostic drive, and per-channel force-off and reduced-current requests for the current sources. Two policy bits choose between auto-recovery, report-only and no diagnosis. In auto-recovery, the failing channel is held at reduced current and every other channel is switched off. In report-only, the only response is the diagnostic line. The PWM generator and the analog sensing sit outside this block and only consume its requests.

Debounce state machine (one per filtered input), states: `DB_CLEAR` (no fault), `DB_ARMING` (fault seen, counting ticks), `DB_HELD` (fault accepted), `DB_RELEASING` (fault gone, counting ticks). Transitions: CLEAR to ARMING when enabled and the raw flag is high. ARMING back to CLEAR when the flag drops or the enable drops. ARMING to HELD on the tick that completes the window. HELD to RELEASING when enabled and the flag is low. RELEASING back to HELD when the flag returns or the enable drops. RELEASING to CLEAR on the tick that completes the window. Policy register, states: `POL_OFF`, `POL_AUTO`, `POL_DETECT`. Bits 10 go to AUTO, 01 to DETECT and 00 to OFF. Bits 11 hold the current state.

Top module: `openload_supervisor`

## Requirements
- R1: A channel's open-load flag is accepted (status bit 0 high, fault register bit set) only after it has stayed high through HOLD_TICKS (default 10) consecutive `ms_tick` pulses. A shorter run is forgotten.
- R2: An accepted open load is dropped only after the raw flag has stayed low through HOLD_TICKS ticks. A return of the flag during that window keeps it accepted.
- R3: While `diag_en` is low, no new open load is accepted and accepted faults are kept. Status bit 4 shows the live `diag_en` level.
- R4: Policy bits {`cfg_autorec`,`cfg_detonly`}: 10 selects auto-recovery, 01 selects report-only, 00 disables open-load diagnosis, and 11 keeps the previous policy. Reset selects no diagnosis.
- R5: In auto-recovery with an accepted open load, `diag_oe` is high, `ch_low` marks the faulty channels and `ch_off` marks all others. Once the fault is dropped, all three return to zero.
- R6: In report-only, an accepted open load sets `diag_oe` while `ch_off` and `ch_low` stay zero.
- R7: The diagnostic line held low by something other than this block for HOLD_TICKS ticks, while `diag_en` is high, sets status bit 1. In auto-recovery this forces every `ch_off` bit high and `ch_low` to zero. In report-only it has no effect on the outputs.
- R8: Status bit 3 (thermal warning) and bit 2 (thermal shutdown) set from their inputs and clear only on a `stat_rd` pulse taken while the input is low. `temp_shut` high drives `diag_oe`.
- R9: Status bit 7 (set-resistor short) sets after HOLD_TICKS ticks of `rset_short` and clears after HOLD_TICKS ticks of its absence. While it is set, `diag_oe` is high.
- R10: Bit i of `fault_reg` is set whenever channel i has an accepted open load and stays set until a `flt_rd` pulse, which reloads it with the channels still accepted.
- R11: Status layout from bit 7 down to bit 0: set-resistor short, communication error, undervoltage, diag range, thermal warning, thermal shutdown, external diagnostic error, open load. Bit 5 follows `uv` live. Bit 6 sets on `comm_err` and clears on `stat_rd`.
- R12: After reset, `status`, `fault_reg`, `ch_off`, `ch_low` and `diag_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ol_raw | input | NCH | Raw open-load comparator flags |
| diag_en | input | 1 | Diagnostic-enable level |
| diag_in | input | 1 | Sensed level of the diagnostic line (low = asserted) |
| cfg_autorec | input | 1 | Policy bit: auto-recovery |
| cfg_detonly | input | 1 | Policy bit: report-only |
| temp_warn | input | 1 | Thermal warning flag |
| temp_shut | input | 1 | Thermal shutdown flag |
| rset_short | input | 1 | Set-resistor short flag |
| uv | input | 1 | Supply undervoltage flag |
| comm_err | input | 1 | Communication error strobe |
| stat_rd | input | 1 | Status byte read pulse |
| flt_rd | input | 1 | Fault register read pulse |
| status | output | 8 | Status byte |
| fault_reg | output | NCH | Per-channel latched fault register |
| diag_oe | output | 1 | Pull the diagnostic line low |
| ch_off | output | NCH | Per-channel force-off request |
| ch_low | output | NCH | Per-channel reduced-current request |

## Verification
The assertions assume that the read pulses and the tick last one cycle. They also assume that the policy inputs stay put for at least two cycles before their effect on the channel requests is judged, and that `diag_in` reflects this block's own pull-down in the same cycle. The stimulus drives every input at the falling edge and holds each level for several cycles. It models the diagnostic line as the wired-AND of the block's drive and an external force, and it sends ticks only as isolated single-cycle pulses, so each window length is an exact count of pulses.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    typedef enum logic [1:0] {
        DB_CLEAR     = 2'd0,
        DB_ARMING    = 2'd1,
        DB_HELD      = 2'd2,
        DB_RELEASING = 2'd3
    } db_state_e;

    typedef enum logic [1:0] {
        POL_OFF    = 2'd0,
        POL_AUTO   = 2'd1,
        POL_DETECT = 2'd2
    } policy_e;

    localparam int STATUS_W = 8;
endpackage

// File: rtl/fsup_debounce.sv
module fsup_debounce
    import fsup_pkg::*;
#(
    parameter int HOLD_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic raw,
    output logic accepted
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    db_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DB_CLEAR;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DB_CLEAR: begin
                if (en && raw) begin
                    st_d  = DB_ARMING;
                    cnt_d = '0;
                end
            end
            DB_ARMING: begin
                if (!en || !raw) begin
                    st_d = DB_CLEAR;
                end else if (tick) begin
                    if (cnt_q == LAST) st_d = DB_HELD;
                    else cnt_d = cnt_q + 1'b1;
                end
            end
            DB_HELD: begin
                if (en && !raw) begin
                    st_d  = DB_RELEASING;
                    cnt_d = '0;
                end
            end
            DB_RELEASING: begin
                if (!en || raw) begin
                    st_d = DB_HELD;
                end else if (tick) begin
                    if (cnt_q == LAST) st_d = DB_CLEAR;
                    else cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = DB_CLEAR;
        endcase
    end

    always_comb begin
        accepted = (st_q == DB_HELD) || (st_q == DB_RELEASING);
    end
endmodule

// File: rtl/fsup_policy.sv
module fsup_policy
    import fsup_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_auto,
    input  logic    sel_detect,
    output policy_e policy
);
    policy_e pol_q, pol_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= POL_OFF;
        else        pol_q <= pol_d;
    end

    always_comb begin
        pol_d = pol_q;
        unique case ({sel_auto, sel_detect})
            2'b10:   pol_d = POL_AUTO;
            2'b01:   pol_d = POL_DETECT;
            2'b00:   pol_d = POL_OFF;
            default: pol_d = pol_q;
        endcase
    end

    assign policy = pol_q;
endmodule

// File: rtl/fsup_status.sv
module fsup_status
    import fsup_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      ol_acc,
    input  logic                ext_err,
    input  logic                rset_err,
    input  logic                temp_warn,
    input  logic                temp_shut,
    input  logic                diag_en,
    input  logic                uv,
    input  logic                comm_err,
    input  logic                stat_rd,
    input  logic                flt_rd,
    output logic [STATUS_W-1:0] status,
    output logic [NCH-1:0]      fault_reg
);
    logic           tw_q, tsd_q, cerr_q;
    logic [NCH-1:0] flt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_q   <= 1'b0;
            tsd_q  <= 1'b0;
            cerr_q <= 1'b0;
            flt_q  <= '0;
        end else begin
            tw_q   <= temp_warn | (tw_q & ~stat_rd);
            tsd_q  <= temp_shut | (tsd_q & ~stat_rd);
            cerr_q <= comm_err | (cerr_q & ~stat_rd);
            flt_q  <= flt_rd ? ol_acc : (flt_q | ol_acc);
        end
    end

    always_comb begin
        status    = {rset_err, cerr_q, uv, diag_en, tw_q, tsd_q, ext_err, |ol_acc};
        fault_reg = flt_q;
    end
endmodule

// File: rtl/openload_supervisor.sv
module openload_supervisor
    import fsup_pkg::*;
#(
    parameter int NCH        = 12,
    parameter int HOLD_TICKS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ms_tick,
    input  logic [NCH-1:0]      ol_raw,
    input  logic                diag_en,
    input  logic                diag_in,
    input  logic                cfg_autorec,
    input  logic                cfg_detonly,
    input  logic                temp_warn,
    input  logic                temp_shut,
    input  logic                rset_short,
    input  logic                uv,
    input  logic                comm_err,
    input  logic                stat_rd,
    input  logic                flt_rd,
    output logic [STATUS_W-1:0] status,
    output logic [NCH-1:0]      fault_reg,
    output logic                diag_oe,
    output logic [NCH-1:0]      ch_off,
    output logic [NCH-1:0]      ch_low
);
    policy_e        policy;
    logic [NCH-1:0] ol_acc;
    logic           ext_err, rset_err, ol_any, ol_en, ext_low;
    logic           diag_q, diag_d;
    logic [NCH-1:0] off_q, off_d, low_q, low_d;

    fsup_policy u_policy (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_auto   (cfg_autorec),
        .sel_detect (cfg_detonly),
        .policy     (policy)
    );

    assign ol_en   = diag_en && (policy != POL_OFF);
    assign ext_low = ~diag_in & ~diag_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        fsup_debounce #(.HOLD_TICKS(HOLD_TICKS)) u_db (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ms_tick),
            .en       (ol_en),
            .raw      (ol_raw[g]),
            .accepted (ol_acc[g])
        );
    end

    fsup_debounce #(.HOLD_TICKS(HOLD_TICKS)) u_db_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ms_tick),
        .en       (diag_en),
        .raw      (ext_low),
        .accepted (ext_err)
    );

    fsup_debounce #(.HOLD_TICKS(HOLD_TICKS)) u_db_rset (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ms_tick),
        .en       (1'b1),
        .raw      (rset_short),
        .accepted (rset_err)
    );

    fsup_status #(.NCH(NCH)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ol_acc    (ol_acc),
        .ext_err   (ext_err),
        .rset_err  (rset_err),
        .temp_warn (temp_warn),
        .temp_shut (temp_shut),
        .diag_en   (diag_en),
        .uv        (uv),
        .comm_err  (comm_err),
        .stat_rd   (stat_rd),
        .flt_rd    (flt_rd),
        .status    (status),
        .fault_reg (fault_reg)
    );

    assign ol_any = |ol_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diag_q <= 1'b0;
            off_q  <= '0;
            low_q  <= '0;
        end else begin
            diag_q <= diag_d;
            off_q  <= off_d;
            low_q  <= low_d;
        end
    end

    always_comb begin
        diag_d = ((policy != POL_OFF) && ol_any) || rset_err || temp_shut;
        off_d  = '0;
        low_d  = '0;
        unique case (policy)
            POL_AUTO: begin
                if (ext_err) begin
                    off_d = '1;
                end else if (ol_any) begin
                    low_d = ol_acc;
                    off_d = ~ol_acc;
                end
            end
            POL_DETECT: ;
            POL_OFF:    ;
            default:    ;
        endcase
    end

    assign diag_oe = diag_q;
    assign ch_off  = off_q;
    assign ch_low  = low_q;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
    parameter int NCH = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_autorec,
    input logic           cfg_detonly,
    input logic           stat_rd,
    input logic           flt_rd,
    input logic [7:0]     status,
    input logic [NCH-1:0] fault_reg,
    input logic           diag_oe,
    input logic [NCH-1:0] ch_off,
    input logic [NCH-1:0] ch_low
);
    // R5: a channel is never both reduced and switched off
    a_r5_low_off_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_low & ch_off) == '0);

    // R5: a reduced-current request comes with the diagnostic drive
    a_r5_low_drives_diag: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_low != '0) |-> diag_oe);

    // R6: report-only leaves channel control alone
    a_r6_detect_no_action: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_detonly, 2) && !$past(cfg_autorec, 2)) |-> (ch_off == '0 && ch_low == '0));

    // R8: thermal shutdown flag holds until a read
    a_r8_tsd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(stat_rd) && $past(status[2])) |-> status[2]);

    // R8: thermal warning flag holds until a read
    a_r8_tw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(stat_rd) && $past(status[3])) |-> status[3]);

    // R9: resistor short drives the diagnostic line
    a_r9_rset_diag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status[7]) |-> diag_oe);

    // R10: a read with no live open load leaves the register empty
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flt_rd) && !$past(status[0])) |-> (fault_reg == '0));

    // R11: communication error holds until a read
    a_r11_cerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(stat_rd) && $past(status[6])) |-> status[6]);
endmodule

bind openload_supervisor fsup_checker #(.NCH(NCH)) u_fsup_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_autorec (cfg_autorec),
    .cfg_detonly (cfg_detonly),
    .stat_rd     (stat_rd),
    .flt_rd      (flt_rd),
    .status      (status),
    .fault_reg   (fault_reg),
    .diag_oe     (diag_oe),
    .ch_off      (ch_off),
    .ch_low      (ch_low)
);

// File: tb/openload_supervisor_test.sv
module openload_supervisor_test;
    localparam int NCH  = 12;
    localparam int HOLD = 10;
    localparam logic [NCH-1:0] ALL = '1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ms_tick = 1'b0;
    logic [NCH-1:0] ol_raw = '0;
    logic           diag_en = 1'b0;
    logic           diag_in;
    logic           ext_force = 1'b0;
    logic           cfg_autorec = 1'b0, cfg_detonly = 1'b0;
    logic           temp_warn = 1'b0, temp_shut = 1'b0, rset_short = 1'b0;
    logic           uv = 1'b0, comm_err = 1'b0, stat_rd = 1'b0, flt_rd = 1'b0;
    logic [7:0]     status;
    logic [NCH-1:0] fault_reg, ch_off, ch_low;
    logic           diag_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign diag_in = ~(diag_oe | ext_force);

    openload_supervisor #(.NCH(NCH), .HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ol_raw(ol_raw),
        .diag_en(diag_en), .diag_in(diag_in), .cfg_autorec(cfg_autorec),
        .cfg_detonly(cfg_detonly), .temp_warn(temp_warn), .temp_shut(temp_shut),
        .rset_short(rset_short), .uv(uv), .comm_err(comm_err), .stat_rd(stat_rd),
        .flt_rd(flt_rd), .status(status), .fault_reg(fault_reg), .diag_oe(diag_oe),
        .ch_off(ch_off), .ch_low(ch_low)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic pulse_stat_rd();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        idle(1);
    endtask

    task automatic pulse_flt_rd();
        @(negedge clk) flt_rd = 1'b1;
        @(negedge clk) flt_rd = 1'b0;
        idle(1);
    endtask

    task automatic set_policy(input logic a, input logic d);
        @(negedge clk);
        cfg_autorec = a;
        cfg_detonly = d;
        idle(3);
    endtask

    task automatic raise_fault(input logic [NCH-1:0] m);
        @(negedge clk) ol_raw = m;
        idle(2);
        tick(HOLD);
        idle(3);
    endtask

    task automatic drop_fault();
        @(negedge clk) ol_raw = '0;
        idle(2);
        tick(HOLD);
        idle(3);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        // R12 reset state
        check("R12 status", status, 0);
        check("R12 fault_reg", fault_reg, 0);
        check("R12 diag_oe", diag_oe, 0);
        check("R12 ch_off", ch_off, 0);
        check("R12 ch_low", ch_low, 0);

        // R4: policy 00 means no open-load diagnosis
        diag_en = 1'b1;
        raise_fault(12'h001);
        check("R4 off no latch", status[0], 0);
        check("R4 off no diag", diag_oe, 0);
        @(negedge clk) ol_raw = '0;
        idle(2);

        // R1: window sweep
        set_policy(1'b1, 1'b0);
        for (int len = 1; len <= HOLD + 2; len++) begin
            @(negedge clk) ol_raw = 12'h020;
            idle(2);
            tick(len);
            idle(2);
            check($sformatf("R1 len %0d", len), status[0], (len >= HOLD) ? 1 : 0);
            drop_fault();
            check($sformatf("R2 cleared after len %0d", len), status[0], 0);
        end
        // R10 fault register sticky then cleared by read
        check("R10 sticky", fault_reg, 32'h020);
        pulse_flt_rd();
        check("R10 read clears", fault_reg, 0);

        // R5/R2: auto-recovery per channel
        for (int i = 0; i < NCH; i++) begin
            logic [NCH-1:0] m;
            m = NCH'(1) << i;
            raise_fault(m);
            check($sformatf("R5 ch%0d low", i), ch_low, m);
            check($sformatf("R5 ch%0d off", i), ch_off, ~m & ALL);
            check($sformatf("R5 ch%0d diag", i), diag_oe, 1);
            @(negedge clk) ol_raw = '0;
            idle(2);
            tick(HOLD - 5);
            @(negedge clk) ol_raw = m;
            idle(3);
            check($sformatf("R2 ch%0d return keeps", i), status[0], 1);
            drop_fault();
            check($sformatf("R2 ch%0d released", i), status[0], 0);
            check($sformatf("R5 ch%0d off rel", i), ch_off, 0);
            check($sformatf("R5 ch%0d diag rel", i), diag_oe, 0);
        end
        pulse_flt_rd();
        check("R10 read after sweep", fault_reg, 0);

        // R4: 11 keeps auto-recovery
        set_policy(1'b1, 1'b1);
        raise_fault(12'h004);
        check("R4 keep auto low", ch_low, 32'h004);
        drop_fault();

        // R6: report-only
        set_policy(1'b0, 1'b1);
        raise_fault(12'h080);
        check("R6 diag", diag_oe, 1);
        check("R6 off", ch_off, 0);
        check("R6 low", ch_low, 0);
        set_policy(1'b1, 1'b1);
        check("R4 keep detect off", ch_off, 0);
        check("R4 keep detect diag", diag_oe, 1);
        drop_fault();
        check("R6 released", diag_oe, 0);

        // R3: disable keeps, blocks new
        set_policy(1'b1, 1'b0);
        raise_fault(12'h002);
        @(negedge clk) diag_en = 1'b0;
        ol_raw = 12'h200;
        idle(2);
        tick(HOLD + 2);
        idle(3);
        check("R3 kept", status[0], 1);
        check("R3 range bit", status[4], 0);
        check("R3 no new low", ch_low, 32'h002);
        @(negedge clk) diag_en = 1'b1;
        drop_fault();
        check("R3 released after enable", status[0], 0);
        pulse_flt_rd();

        // R7: external diagnostic error
        @(negedge clk) ext_force = 1'b1;
        idle(2);
        tick(HOLD);
        idle(3);
        check("R7 flag", status[1], 1);
        check("R7 auto all off", ch_off, ALL);
        @(negedge clk) ext_force = 1'b0;
        idle(2);
        tick(HOLD);
        idle(3);
        check("R7 flag clear", status[1], 0);
        check("R7 off clear", ch_off, 0);
        set_policy(1'b0, 1'b1);
        @(negedge clk) ext_force = 1'b1;
        idle(2);
        tick(HOLD);
        idle(3);
        check("R7 detect flag", status[1], 1);
        check("R7 detect no off", ch_off, 0);
        @(negedge clk) ext_force = 1'b0;
        idle(2);
        tick(HOLD);
        idle(3);
        @(negedge clk) diag_en = 1'b0;
        ext_force = 1'b1;
        idle(2);
        tick(HOLD + 2);
        idle(3);
        check("R7 disabled no flag", status[1], 0);
        @(negedge clk) ext_force = 1'b0;
        diag_en = 1'b1;
        idle(2);

        // R8: thermal flags
        @(negedge clk) temp_warn = 1'b1;
        idle(2);
        check("R8 tw set", status[3], 1);
        pulse_stat_rd();
        check("R8 tw read while hot", status[3], 1);
        @(negedge clk) temp_warn = 1'b0;
        idle(2);
        check("R8 tw holds", status[3], 1);
        pulse_stat_rd();
        check("R8 tw cleared", status[3], 0);
        @(negedge clk) temp_shut = 1'b1;
        idle(3);
        check("R8 tsd set", status[2], 1);
        check("R8 tsd diag", diag_oe, 1);
        @(negedge clk) temp_shut = 1'b0;
        idle(3);
        check("R8 tsd holds", status[2], 1);
        check("R8 tsd diag rel", diag_oe, 0);
        pulse_stat_rd();
        check("R8 tsd cleared", status[2], 0);

        // R9: set-resistor short
        @(negedge clk) rset_short = 1'b1;
        idle(2);
        tick(HOLD - 1);
        idle(3);
        check("R9 not yet", status[7], 0);
        tick(1);
        idle(3);
        check("R9 set", status[7], 1);
        check("R9 diag", diag_oe, 1);
        @(negedge clk) rset_short = 1'b0;
        idle(2);
        tick(HOLD);
        idle(3);
        check("R9 cleared", status[7], 0);

        // R11: layout
        @(negedge clk) uv = 1'b1;
        idle(2);
        check("R11 uv+range", status, 8'h30);
        @(negedge clk) uv = 1'b0;
        comm_err = 1'b1;
        @(negedge clk) comm_err = 1'b0;
        idle(2);
        check("R11 comm err", status, 8'h50);
        pulse_stat_rd();
        check("R11 comm cleared", status, 8'h10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule